// File: doc/BRIEF.md
# Position-Based Chain Address Assignment

This block sits in a bus slave node and gives the node a unique bus address from where it sits in a wired daisy chain. No per-node programming or coding resistor is needed. Each node has one chain input, wired to the previous node's chain output, and one chain output, wired to the next node's input. The master's own output is held low. Every slave holds its output high while addressing runs, so only the first unaddressed slave in the chain sees a low input.

A selected node takes the address carried by the next decoded configuration message and keeps it. It then pulls its own chain output low, which selects the following node. The step repeats down the chain until every node has an address. All nodes carry identical logic. Message decoding and the physical layer sit outside the block: it sees only a one-cycle strobe with the message address.

The chain input is synchronised and must stay low for a set number of cycles before it counts. A start command restarts the procedure from any state.

Top module: `addr_chain_node`

## Requirements
- R1: After reset, `chainOut` is 1, `addrValid` is 0 and `nodeAddr` is 0. The node ignores chain input and messages until the first `startCmd`.
- R2: A `startCmd` in any state clears `nodeAddr` to 0, drops `addrValid` and drives `chainOut` high in the cycle that follows. The node then waits to be selected.
- R3: The node counts as selected only when its synchronised chain input (two flip-flop stages) has been low for `SEL_CYCLES` consecutive cycles. A low pulse of `SEL_CYCLES`-1 cycles or fewer does not select it.
- R4: While the node is waiting for selection, configuration messages have no effect on `nodeAddr` or `addrValid`.
- R5: A selected node stores `msgAddr` on the first `msgStrobe` with a nonzero address. `addrValid` is 1 and `nodeAddr` equals that address from the clock edge that samples the strobe.
- R6: A message whose address is 0 is rejected. The node stays selected and takes the next nonzero message.
- R7: `chainOut` is low exactly when `addrValid` is 1. This selects the next node in the chain.
- R8: Once addressed, the node ignores later messages and changes on the chain input until the next `startCmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startCmd | input | 1 | One-cycle pulse that (re)starts addressing |
| chainIn | input | 1 | Chain input from the previous node (asynchronous) |
| msgStrobe | input | 1 | One-cycle strobe: a decoded configuration message is present |
| msgAddr | input | ADDR_W | Address carried by the configuration message |
| chainOut | output | 1 | Chain output to the next node; low once addressed |
| nodeAddr | output | ADDR_W | Assigned address, 0 when unassigned |
| addrValid | output | 1 | High while `nodeAddr` holds an assigned address |

## Verification
The properties assume that `msgStrobe`, `msgAddr` and `startCmd` are synchronous to `clk` and that each strobe or start lasts one cycle. They make no assumption about `chainIn`, because the block synchronises it. The stimulus drives every input just after the falling edge and gives strobes and starts a width of exactly one cycle. It changes the chain input only in whole-cycle low pulses, and it leaves four idle cycles after each pulse before sending a message. The selection outcome therefore depends only on the pulse length and not on synchroniser phase.

// File: rtl/addr_chain_pkg.sv
package addr_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_SEL = 2'd1,
    ST_WAIT_MSG = 2'd2,
    ST_DONE     = 2'd3
  } chainState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic filtEn;    // run the low-level qualification counter
    logic loadAddr;  // capture message address
    logic clrAddr;   // clear stored address
  } dpStrobe_t;

endpackage

// File: rtl/addr_chain_dp.sv
module addr_chain_dp
  import addr_chain_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SEL_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chainIn,
  input  logic [ADDR_W-1:0] msgAddr,
  input  dpStrobe_t         stb,
  output logic              selReady,
  output logic              msgAddrOk,
  output logic [ADDR_W-1:0] nodeAddr
);

  localparam int CNT_W = $clog2(SEL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SEL_CYCLES);

  logic             syncOut;
  logic [CNT_W-1:0] lowCnt;

  // Input synchroniser; reset value matches an idle (high) chain
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= chainIn;
      end
      assign syncOut = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], chainIn};
      end
      assign syncOut = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // Consecutive-low counter, saturating at the qualification length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (!stb.filtEn || syncOut) begin
      lowCnt <= '0;
    end else if (lowCnt != CNT_MAX) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign selReady  = (lowCnt == CNT_MAX);
  assign msgAddrOk = |msgAddr;

  // Address register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nodeAddr <= '0;
    end else if (stb.clrAddr) begin
      nodeAddr <= '0;
    end else if (stb.loadAddr) begin
      nodeAddr <= msgAddr;
    end
  end

endmodule

// File: rtl/addr_chain_ctrl.sv
module addr_chain_ctrl
  import addr_chain_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startCmd,
  input  logic      msgStrobe,
  input  logic      selReady,
  input  logic      msgAddrOk,
  output dpStrobe_t stb,
  output logic      chainOut,
  output logic      addrValid
);

  chainState_t state, nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    if (startCmd) begin
      nextState   = ST_WAIT_SEL;
      stb.clrAddr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: nextState = ST_IDLE;
        ST_WAIT_SEL: begin
          stb.filtEn = 1'b1;
          if (selReady) nextState = ST_WAIT_MSG;
        end
        ST_WAIT_MSG: begin
          if (msgStrobe && msgAddrOk) begin
            nextState    = ST_DONE;
            stb.loadAddr = 1'b1;
          end
        end
        ST_DONE: nextState = ST_DONE;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      chainOut  <= 1'b1;
      addrValid <= 1'b0;
    end else begin
      state     <= nextState;
      chainOut  <= (nextState != ST_DONE);
      addrValid <= (nextState == ST_DONE);
    end
  end

endmodule

// File: rtl/addr_chain_node.sv
module addr_chain_node
  import addr_chain_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SEL_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startCmd,
  input  logic              chainIn,
  input  logic              msgStrobe,
  input  logic [ADDR_W-1:0] msgAddr,
  output logic              chainOut,
  output logic [ADDR_W-1:0] nodeAddr,
  output logic              addrValid
);

  dpStrobe_t stb;
  logic      selReady;
  logic      msgAddrOk;

  addr_chain_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startCmd  (startCmd),
    .msgStrobe (msgStrobe),
    .selReady  (selReady),
    .msgAddrOk (msgAddrOk),
    .stb       (stb),
    .chainOut  (chainOut),
    .addrValid (addrValid)
  );

  addr_chain_dp #(
    .ADDR_W      (ADDR_W),
    .SEL_CYCLES  (SEL_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .chainIn   (chainIn),
    .msgAddr   (msgAddr),
    .stb       (stb),
    .selReady  (selReady),
    .msgAddrOk (msgAddrOk),
    .nodeAddr  (nodeAddr)
  );

endmodule

// File: rtl/addr_chain_node_chk.sv
module addr_chain_node_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              startCmd,
  input logic              msgStrobe,
  input logic [ADDR_W-1:0] msgAddr,
  input logic              chainOut,
  input logic [ADDR_W-1:0] nodeAddr,
  input logic              addrValid
);

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> (!addrValid && chainOut && nodeAddr == '0));

  p_capture_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrValid) |-> ($past(msgStrobe) && $past(msgAddr) == nodeAddr));

  p_zero_reject_r6: assert property (@(posedge clk) disable iff (!rstN)
    (msgStrobe && msgAddr == '0 && !addrValid && !startCmd) |=> !addrValid);

  p_out_low_when_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    chainOut != addrValid);

  p_hold_addressed_r8: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !startCmd) |=> (addrValid && $stable(nodeAddr)));

  p_valid_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> nodeAddr != '0);

endmodule

bind addr_chain_node addr_chain_node_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startCmd  (startCmd),
  .msgStrobe (msgStrobe),
  .msgAddr   (msgAddr),
  .chainOut  (chainOut),
  .nodeAddr  (nodeAddr),
  .addrValid (addrValid)
);

// File: tb/test_addr_chain_node.sv
`timescale 1ns/1ps
module test_addr_chain_node;

  localparam int ADDR_W = 6;
  localparam int SEL    = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startCmd = 1'b0;
  logic              chainIn = 1'b1;
  logic              msgStrobe = 1'b0;
  logic [ADDR_W-1:0] msgAddr = '0;
  logic              chainOut;
  logic [ADDR_W-1:0] nodeAddr;
  logic              addrValid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  addr_chain_node #(.ADDR_W(ADDR_W), .SEL_CYCLES(SEL), .SYNC_STAGES(2)) i_addr_chain_node (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .chainIn(chainIn),
    .msgStrobe(msgStrobe), .msgAddr(msgAddr),
    .chainOut(chainOut), .nodeAddr(nodeAddr), .addrValid(addrValid)
  );

  // Expected-value functions from the requirements
  function automatic bit expSelected(int lowLen);
    return lowLen >= SEL;                       // R3
  endfunction

  function automatic logic [ADDR_W-1:0] expAddr(bit sel, logic [ADDR_W-1:0] a,
                                                logic [ADDR_W-1:0] b);
    if (!sel) return '0;                         // R4
    if (a != '0) return a;                       // R5
    return b;                                    // R6
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendMsg(logic [ADDR_W-1:0] a);
    @(negedge clk);
    msgStrobe = 1'b1; msgAddr = a;
    @(negedge clk);
    msgStrobe = 1'b0; msgAddr = '0;
  endtask

  task automatic restart();
    @(negedge clk);
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
  endtask

  task automatic lowPulse(int len);
    @(negedge clk);
    chainIn = 1'b0;
    cyc(len);
    chainIn = 1'b1;
    cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    check(chainOut == 1'b1, "R1 chainOut", chainOut, 1);
    check(addrValid == 1'b0, "R1 addrValid", addrValid, 0);
    check(nodeAddr == '0, "R1 nodeAddr", nodeAddr, 0);

    // R1 before start: low input and message ignored
    lowPulse(SEL + 3);
    sendMsg(6'd5);
    check(addrValid == 1'b0, "R1 idle ignores msg", addrValid, 0);

    // R4 input high: message ignored
    restart();
    sendMsg(6'd7);
    check(addrValid == 1'b0 && nodeAddr == '0, "R4 unselected ignores msg", nodeAddr, 0);

    // R3 glitch one cycle short of qualification
    lowPulse(SEL - 1);
    sendMsg(6'd9);
    check(addrValid == 1'b0, "R3 short pulse not selected", addrValid, 0);

    // R3 exact length, R6 zero rejected, R5 capture, R7 output
    lowPulse(SEL);
    sendMsg(6'd0);
    check(addrValid == 1'b0, "R6 zero address rejected", addrValid, 0);
    check(chainOut == 1'b1, "R6 chainOut stays high", chainOut, 1);
    sendMsg(6'd11);
    check(addrValid == 1'b1, "R5 addrValid set", addrValid, 1);
    check(nodeAddr == 6'd11, "R5 nodeAddr", nodeAddr, 11);
    check(chainOut == 1'b0, "R7 chainOut low", chainOut, 0);

    // R8 later message and input activity ignored
    sendMsg(6'd22);
    lowPulse(SEL + 2);
    check(nodeAddr == 6'd11 && addrValid, "R8 address held", nodeAddr, 11);

    // R2 restart from addressed state
    restart();
    check(addrValid == 1'b0 && chainOut == 1'b1 && nodeAddr == '0,
          "R2 restart clears", nodeAddr, 0);

    // R2 restart while waiting for message discards the selection
    lowPulse(SEL + 1);
    restart();
    sendMsg(6'd13);
    check(addrValid == 1'b0, "R2 restart drops selection", addrValid, 0);

    // Random pulse lengths and addresses
    for (int i = 0; i < 40; i++) begin
      int len;
      logic [ADDR_W-1:0] a, b, e;
      bit sel;
      len = 1 + int'($urandom % 8);
      a   = ($urandom % 4 == 0) ? '0 : ADDR_W'($urandom);
      b   = ADDR_W'(1 + ($urandom % 63));
      restart();
      lowPulse(len);
      sendMsg(a);
      if (a == '0) sendMsg(b);
      sel = expSelected(len);
      e = expAddr(sel, a, b);
      check(nodeAddr == e, "R3 R5 R6 random nodeAddr", nodeAddr, e);
      check(addrValid == sel, "R3 random addrValid", addrValid, sel);
      check(chainOut == !sel, "R7 random chainOut", chainOut, !sel);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule